// File: doc/BRIEF.md
# ACPI Power-State Sequencing Controller

This block drives the board-level power signals of a system controller from a handful of supply and sleep inputs and a set of static configuration bits. When the 3.3 V supply-good input has been high for a programmable number of 100 ms units, it raises the power-good output. It turns the sleep-request input into the power-supply enable, PSON#. That enable can be held off until the supply has stayed off for at least four seconds. It filters the ATX power-good and LPC reset inputs and fans the filtered reset out to five PCI reset outputs. Each PCI reset can be forced low one at a time.

The block keeps two registered power states, S3 (suspend) and S5 (soft-off). The S3 condition comes either from the supply-good input or from the sleep pin combined with a software request. A configuration bit picks the source. The S5 condition comes from an active-low soft-off request. Four rail-timing outputs and two gate outputs are modelled as a data bit plus an output enable. Outside sleep they drive high. In sleep, each one either drives low or floats, as its own configuration bit selects. A watchdog-reset output can follow the power-good output.

All time is counted on a single-cycle `tick` pulse that an external prescaler supplies once per 100 ms unit. Filtering is counted on the system clock.

Top module: `acpi_pwr_seq`

## Requirements
- R1: After `vddOk` is sampled high, `pwrOk` rises at the clock edge that samples the (N+1)-th `tick` pulse, where N is the value of `delaySel`. So `delaySel` = 2'b00 gives one 100 ms unit and 2'b11 gives four units.
- R2: When `vddOk` is sampled low, `pwrOk` is low after the next edge. Any delay already counted is discarded, so the next rise counts again from zero ticks.
- R3: With its enable bit set, a filtered input (`atxPgOut`, and the internal LPC reset) takes a new value only after 16 consecutive clock samples of its two-flop-synchronised input that differ from the current filtered value. With the enable bit clear, the filtered output equals the synchronised input.
- R4: Each bit i of `pciRstN` equals the filtered LPC reset AND `pciGate[i]`. Bit 0 of `pciGate` controls `pciRstN[0]`, and a 0 forces that output low.
- R5: The S3 state is registered one edge after its condition. With `s3SrcSel` = 0 the condition is `vddOk` low. With `s3SrcSel` = 1 the condition is `s3ReqN` low or `swS3` high. S5 is registered one edge after `slpS5N` is low.
- R6: With `psonDelayEn` = 0, `psonN` equals the inverse of `s3ReqN` as sampled at the previous edge.
- R7: With `psonDelayEn` = 1, `psonN` may fall only when at least 40 `tick` pulses have been seen since it last went high. The count saturates at 40 and starts saturated after reset.
- R8: Outside S3 and S5, every rail output drives high (`railData` = 1, `railOe` = 1). In S3 or S5, rail i drives low when `railFloat[i]` = 0 and floats (`railOe[i]` = 0) when it is 1.
- R9: In S5, gate outputs `s0Gate*` and `s3Gate*` drive low when their float bit is 0 and float when it is 1. Outside S5 they drive high.
- R10: `wdtRstN` is low exactly when `wdtFromPwrokEn` = 1 and `pwrOk` = 0.
- R11: While `rstN` is low, the outputs are `pwrOk` = 0, `psonN` = 1, `atxPgOut` = 0 and all `pciRstN` = 0, with S3 and S5 inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Single-cycle pulse once per 100 ms unit |
| vddOk | input | 1 | 3.3 V supply good |
| s3ReqN | input | 1 | Sleep request pin, active low |
| swS3 | input | 1 | Software S3 request |
| slpS5N | input | 1 | Soft-off request, active low |
| atxPgIn | input | 1 | Raw ATX power good |
| lpcRstNIn | input | 1 | Raw LPC reset, active low |
| delaySel | input | 2 | Power-good delay, units minus one |
| atxDbEn | input | 1 | Enable filtering of ATX power good |
| lpcDbEn | input | 1 | Enable filtering of LPC reset |
| s3SrcSel | input | 1 | S3 source: 0 supply-good, 1 pin or software |
| psonDelayEn | input | 1 | Enable four-second off-time guard |
| pciGate | input | 5 | Per-output PCI reset gate, 0 forces low |
| railFloat | input | 4 | Per-rail float-in-sleep selection |
| s0GateFloat | input | 1 | S0 gate floats in S5 when 1 |
| s3GateFloat | input | 1 | S3 gate floats in S5 when 1 |
| wdtFromPwrokEn | input | 1 | Let power-good drive the watchdog reset |
| pwrOk | output | 1 | Delayed power good |
| wdtRstN | output | 1 | Watchdog reset, active low |
| psonN | output | 1 | Power-supply enable, active low |
| atxPgOut | output | 1 | Filtered ATX power good |
| pciRstN | output | 5 | PCI reset outputs, active low |
| railData | output | 4 | Rail-timing output data |
| railOe | output | 4 | Rail-timing output enable |
| s0GateData | output | 1 | S0 gate data |
| s0GateOe | output | 1 | S0 gate output enable |
| s3GateData | output | 1 | S3 gate data |
| s3GateOe | output | 1 | S3 gate output enable |

## Verification
The assertions take `tick` to be a pulse no wider than one clock. They also take `vddOk`, `s3ReqN`, `swS3` and `slpS5N` to be synchronous to `clk`, and the configuration bits to change only between sequences. The bench drives every input shortly after a rising edge and generates `tick` once every four clocks. It changes `delaySel` only while `vddOk` is low, so a count in progress never sees its limit move. The raw `atxPgIn` and `lpcRstNIn` are left free to bounce, because they pass through the synchroniser.

// File: rtl/acpi_pwr_seq_pkg.sv
package acpi_pwr_seq_pkg;
  // Strobes passed from the sequencing control to the output datapath.
  typedef struct packed {
    logic pwrOk;
    logic inS3;
    logic inS5;
  } seqStrobe_t;
endpackage

// File: rtl/acpi_pwr_seq_debounce.sv
module acpi_pwr_seq_debounce #(
  parameter int DB_LEN = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic en,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(DB_LEN);

  logic syncA, syncB, filt;
  logic [CW-1:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA  <= 1'b0;
      syncB  <= 1'b0;
      filt   <= 1'b0;
      runCnt <= '0;
    end else begin
      syncA <= din;
      syncB <= syncA;
      if (!en) begin
        filt   <= syncB;
        runCnt <= '0;
      end else if (syncB == filt) begin
        runCnt <= '0;
      end else if (runCnt == CW'(DB_LEN - 1)) begin
        filt   <= syncB;
        runCnt <= '0;
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end
  end

  assign dout = en ? filt : syncB;
endmodule

// File: rtl/acpi_pwr_seq_ctrl.sv
module acpi_pwr_seq_ctrl
  import acpi_pwr_seq_pkg::*;
#(
  parameter int SEL_W     = 2,
  parameter int OFF_TICKS = 40
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             vddOk,
  input  logic             s3ReqN,
  input  logic             swS3,
  input  logic             slpS5N,
  input  logic [SEL_W-1:0] delaySel,
  input  logic             s3SrcSel,
  input  logic             psonDelayEn,
  output seqStrobe_t       strobe,
  output logic             psonN
);
  localparam int OFF_W = $clog2(OFF_TICKS + 1);

  logic             pwrOkQ, inS3Q, inS5Q, psonQ;
  logic [SEL_W-1:0] dlyCnt;
  logic [OFF_W-1:0] offCnt;
  logic             offDone, psonNext, s3Cond;

  assign offDone  = (offCnt == OFF_W'(OFF_TICKS));
  assign psonNext = !s3ReqN || (psonQ && psonDelayEn && !offDone);
  assign s3Cond   = s3SrcSel ? (!s3ReqN || swS3) : !vddOk;

  // Power-good delay: counts tick pulses while supply is good.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwrOkQ <= 1'b0;
      dlyCnt <= '0;
    end else if (!vddOk) begin
      pwrOkQ <= 1'b0;
      dlyCnt <= '0;
    end else if (!pwrOkQ && tick) begin
      if (dlyCnt == delaySel) pwrOkQ <= 1'b1;
      else                    dlyCnt <= dlyCnt + 1'b1;
    end
  end

  // Supply enable with saturating off-time counter.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psonQ  <= 1'b1;
      offCnt <= OFF_W'(OFF_TICKS);
    end else begin
      psonQ <= psonNext;
      if (!psonQ)                 offCnt <= '0;
      else if (tick && !offDone)  offCnt <= offCnt + 1'b1;
    end
  end

  // Registered sleep states.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inS3Q <= 1'b0;
      inS5Q <= 1'b0;
    end else begin
      inS3Q <= s3Cond;
      inS5Q <= !slpS5N;
    end
  end

  assign strobe.pwrOk = pwrOkQ;
  assign strobe.inS3  = inS3Q;
  assign strobe.inS5  = inS5Q;
  assign psonN        = psonQ;
endmodule

// File: rtl/acpi_pwr_seq_datapath.sv
module acpi_pwr_seq_datapath
  import acpi_pwr_seq_pkg::*;
#(
  parameter int NUM_PCI  = 5,
  parameter int NUM_RAIL = 4,
  parameter int DB_LEN   = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          strobe,
  input  logic                atxPgIn,
  input  logic                lpcRstNIn,
  input  logic                atxDbEn,
  input  logic                lpcDbEn,
  input  logic [NUM_PCI-1:0]  pciGate,
  input  logic [NUM_RAIL-1:0] railFloat,
  input  logic                s0GateFloat,
  input  logic                s3GateFloat,
  input  logic                wdtFromPwrokEn,
  output logic                wdtRstN,
  output logic                atxPgOut,
  output logic [NUM_PCI-1:0]  pciRstN,
  output logic [NUM_RAIL-1:0] railData,
  output logic [NUM_RAIL-1:0] railOe,
  output logic                s0GateData,
  output logic                s0GateOe,
  output logic                s3GateData,
  output logic                s3GateOe
);
  localparam int NUM_DB = 2;

  logic [NUM_DB-1:0] dbIn, dbEn, dbOut;
  logic              sleeping;

  assign dbIn = {lpcRstNIn, atxPgIn};
  assign dbEn = {lpcDbEn, atxDbEn};

  for (genvar g = 0; g < NUM_DB; g++) begin : gFilt
    acpi_pwr_seq_debounce #(.DB_LEN(DB_LEN)) u_db (
      .clk (clk),
      .rstN(rstN),
      .en  (dbEn[g]),
      .din (dbIn[g]),
      .dout(dbOut[g])
    );
  end

  assign atxPgOut = dbOut[0];
  assign pciRstN  = pciGate & {NUM_PCI{dbOut[1]}};

  assign sleeping = strobe.inS3 || strobe.inS5;

  for (genvar r = 0; r < NUM_RAIL; r++) begin : gRail
    assign railData[r] = !sleeping;
    assign railOe[r]   = !(sleeping && railFloat[r]);
  end

  assign s0GateData = !strobe.inS5;
  assign s0GateOe   = !(strobe.inS5 && s0GateFloat);
  assign s3GateData = !strobe.inS5;
  assign s3GateOe   = !(strobe.inS5 && s3GateFloat);

  assign wdtRstN = !(wdtFromPwrokEn && !strobe.pwrOk);
endmodule

// File: rtl/acpi_pwr_seq.sv
module acpi_pwr_seq
  import acpi_pwr_seq_pkg::*;
#(
  parameter int SEL_W     = 2,
  parameter int OFF_TICKS = 40,
  parameter int DB_LEN    = 16,
  parameter int NUM_PCI   = 5,
  parameter int NUM_RAIL  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tick,
  input  logic                vddOk,
  input  logic                s3ReqN,
  input  logic                swS3,
  input  logic                slpS5N,
  input  logic                atxPgIn,
  input  logic                lpcRstNIn,
  input  logic [SEL_W-1:0]    delaySel,
  input  logic                atxDbEn,
  input  logic                lpcDbEn,
  input  logic                s3SrcSel,
  input  logic                psonDelayEn,
  input  logic [NUM_PCI-1:0]  pciGate,
  input  logic [NUM_RAIL-1:0] railFloat,
  input  logic                s0GateFloat,
  input  logic                s3GateFloat,
  input  logic                wdtFromPwrokEn,
  output logic                pwrOk,
  output logic                wdtRstN,
  output logic                psonN,
  output logic                atxPgOut,
  output logic [NUM_PCI-1:0]  pciRstN,
  output logic [NUM_RAIL-1:0] railData,
  output logic [NUM_RAIL-1:0] railOe,
  output logic                s0GateData,
  output logic                s0GateOe,
  output logic                s3GateData,
  output logic                s3GateOe
);
  seqStrobe_t strobe;

  acpi_pwr_seq_ctrl #(.SEL_W(SEL_W), .OFF_TICKS(OFF_TICKS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .tick       (tick),
    .vddOk      (vddOk),
    .s3ReqN     (s3ReqN),
    .swS3       (swS3),
    .slpS5N     (slpS5N),
    .delaySel   (delaySel),
    .s3SrcSel   (s3SrcSel),
    .psonDelayEn(psonDelayEn),
    .strobe     (strobe),
    .psonN      (psonN)
  );

  acpi_pwr_seq_datapath #(.NUM_PCI(NUM_PCI), .NUM_RAIL(NUM_RAIL), .DB_LEN(DB_LEN)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .atxPgIn       (atxPgIn),
    .lpcRstNIn     (lpcRstNIn),
    .atxDbEn       (atxDbEn),
    .lpcDbEn       (lpcDbEn),
    .pciGate       (pciGate),
    .railFloat     (railFloat),
    .s0GateFloat   (s0GateFloat),
    .s3GateFloat   (s3GateFloat),
    .wdtFromPwrokEn(wdtFromPwrokEn),
    .wdtRstN       (wdtRstN),
    .atxPgOut      (atxPgOut),
    .pciRstN       (pciRstN),
    .railData      (railData),
    .railOe        (railOe),
    .s0GateData    (s0GateData),
    .s0GateOe      (s0GateOe),
    .s3GateData    (s3GateData),
    .s3GateOe      (s3GateOe)
  );

  assign pwrOk = strobe.pwrOk;
endmodule

// File: rtl/acpi_pwr_seq_checker.sv
module acpi_pwr_seq_checker #(
  parameter int OFF_TICKS = 40,
  parameter int NUM_PCI   = 5,
  parameter int NUM_RAIL  = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                tick,
  input logic                vddOk,
  input logic                s3ReqN,
  input logic                psonDelayEn,
  input logic                wdtFromPwrokEn,
  input logic [NUM_PCI-1:0]  pciGate,
  input logic [NUM_RAIL-1:0] railFloat,
  input logic                pwrOk,
  input logic                wdtRstN,
  input logic                psonN,
  input logic [NUM_PCI-1:0]  pciRstN,
  input logic [NUM_RAIL-1:0] railOe
);
  localparam int OFF_W = $clog2(OFF_TICKS + 1);

  logic             pastValid;
  logic [OFF_W-1:0] offSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pastValid <= 1'b0;
      offSeen   <= OFF_W'(OFF_TICKS);
    end else begin
      pastValid <= 1'b1;
      if (!psonN) offSeen <= '0;
      else if (tick && offSeen != OFF_W'(OFF_TICKS)) offSeen <= offSeen + 1'b1;
    end
  end

  AST_PWROK_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $rose(pwrOk)) |-> ($past(tick) && $past(vddOk))); // R1

  AST_PWROK_DROP: assert property (@(posedge clk) disable iff (!rstN)
    !vddOk |=> !pwrOk); // R2

  for (genvar i = 0; i < NUM_PCI; i++) begin : gPci
    AST_PCI_FORCED: assert property (@(posedge clk) disable iff (!rstN)
      !pciGate[i] |-> !pciRstN[i]); // R4
  end

  AST_PSON_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && !psonDelayEn && !$past(psonDelayEn)) |-> (psonN == !$past(s3ReqN))); // R6

  AST_PSON_OFFTIME: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $fell(psonN) && $past(psonDelayEn))
      |-> ($past(offSeen) == OFF_W'(OFF_TICKS))); // R7

  for (genvar r = 0; r < NUM_RAIL; r++) begin : gRail
    AST_FLOAT_SELECTED: assert property (@(posedge clk) disable iff (!rstN)
      !railOe[r] |-> railFloat[r]); // R8
  end

  AST_WDT_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    !wdtRstN |-> (!pwrOk && wdtFromPwrokEn)); // R10
endmodule

bind acpi_pwr_seq acpi_pwr_seq_checker #(
  .OFF_TICKS(OFF_TICKS), .NUM_PCI(NUM_PCI), .NUM_RAIL(NUM_RAIL)
) u_chk (
  .clk(clk), .rstN(rstN), .tick(tick), .vddOk(vddOk), .s3ReqN(s3ReqN),
  .psonDelayEn(psonDelayEn), .wdtFromPwrokEn(wdtFromPwrokEn),
  .pciGate(pciGate), .railFloat(railFloat), .pwrOk(pwrOk),
  .wdtRstN(wdtRstN), .psonN(psonN), .pciRstN(pciRstN), .railOe(railOe)
);

// File: tb/acpi_pwr_seq_bench.sv
`timescale 1ns/1ps
module acpi_pwr_seq_bench;
  localparam int OFF  = 40;
  localparam int DBL  = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0;
  logic vddOk = 1'b0, s3ReqN = 1'b1, swS3 = 1'b0, slpS5N = 1'b1;
  logic atxPgIn = 1'b0, lpcRstNIn = 1'b0;
  logic [1:0] delaySel = 2'd0;
  logic atxDbEn = 1'b1, lpcDbEn = 1'b1, s3SrcSel = 1'b0, psonDelayEn = 1'b0;
  logic [4:0] pciGate = 5'h1f;
  logic [3:0] railFloat = 4'b0001;
  logic s0GateFloat = 1'b1, s3GateFloat = 1'b1, wdtFromPwrokEn = 1'b0;

  logic pwrOk, wdtRstN, psonN, atxPgOut, s0GateData, s0GateOe, s3GateData, s3GateOe;
  logic [4:0] pciRstN;
  logic [3:0] railData, railOe;

  acpi_pwr_seq u_acpi_pwr_seq (
    .clk(clk), .rstN(rstN), .tick(tick), .vddOk(vddOk), .s3ReqN(s3ReqN),
    .swS3(swS3), .slpS5N(slpS5N), .atxPgIn(atxPgIn), .lpcRstNIn(lpcRstNIn),
    .delaySel(delaySel), .atxDbEn(atxDbEn), .lpcDbEn(lpcDbEn),
    .s3SrcSel(s3SrcSel), .psonDelayEn(psonDelayEn), .pciGate(pciGate),
    .railFloat(railFloat), .s0GateFloat(s0GateFloat), .s3GateFloat(s3GateFloat),
    .wdtFromPwrokEn(wdtFromPwrokEn), .pwrOk(pwrOk), .wdtRstN(wdtRstN),
    .psonN(psonN), .atxPgOut(atxPgOut), .pciRstN(pciRstN), .railData(railData),
    .railOe(railOe), .s0GateData(s0GateData), .s0GateOe(s0GateOe),
    .s3GateData(s3GateData), .s3GateOe(s3GateOe)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  // Tick: one clock high out of every four, changed just after the edge.
  int tickDiv = 0;
  always begin
    @(posedge clk);
    #2;
    tickDiv = (tickDiv + 1) % 4;
    tick = (tickDiv == 0);
  end

  // Behavioural reference model, updated on every rising edge.
  bit mPwr = 0; int mDly = 0;
  bit mPson = 1; int mOff = OFF;
  bit mS3 = 0, mS5 = 0;
  bit s1[2] = '{0, 0};
  bit s2[2] = '{0, 0};
  bit filt[2] = '{0, 0};
  int run[2] = '{0, 0};

  always @(posedge clk) begin
    if (!rstN) begin
      mPwr = 0; mDly = 0; mPson = 1; mOff = OFF; mS3 = 0; mS5 = 0;
      for (int k = 0; k < 2; k++) begin
        s1[k] = 0; s2[k] = 0; filt[k] = 0; run[k] = 0;
      end
    end else begin
      bit nextPson;
      for (int k = 0; k < 2; k++) begin
        bit inb, en;
        inb = (k == 0) ? atxPgIn : lpcRstNIn;
        en  = (k == 0) ? atxDbEn : lpcDbEn;
        if (!en) begin
          filt[k] = s2[k]; run[k] = 0;
        end else if (s2[k] == filt[k]) begin
          run[k] = 0;
        end else begin
          run[k]++;
          if (run[k] == DBL) begin filt[k] = s2[k]; run[k] = 0; end
        end
        s2[k] = s1[k];
        s1[k] = inb;
      end
      if (!vddOk) begin
        mPwr = 0; mDly = 0;
      end else if (!mPwr && tick) begin
        mDly++;
        if (mDly == int'(delaySel) + 1) mPwr = 1;
      end
      nextPson = !s3ReqN || (mPson && psonDelayEn && mOff < OFF);
      if (!mPson) mOff = 0;
      else if (tick && mOff < OFF) mOff++;
      mPson = nextPson;
      mS3 = s3SrcSel ? (!s3ReqN || swS3) : !vddOk;
      mS5 = !slpS5N;
    end
  end

  // Compare every output on every falling edge.
  always @(negedge clk) begin
    if (!done) begin
      bit atxExp, lpcExp, sleep;
      logic [4:0] pciExp;
      logic [3:0] oeExp;
      atxExp = atxDbEn ? filt[0] : s2[0];
      lpcExp = lpcDbEn ? filt[1] : s2[1];
      sleep  = mS3 || mS5;
      pciExp = pciGate & {5{lpcExp}};
      oeExp  = sleep ? ~railFloat : 4'hf;
      chk("R1/R2 pwrOk", {7'd0, pwrOk}, {7'd0, mPwr});
      chk("R3 atxPgOut", {7'd0, atxPgOut}, {7'd0, atxExp});
      chk("R4 pciRstN", {3'd0, pciRstN}, {3'd0, pciExp});
      chk("R6/R7 psonN", {7'd0, psonN}, {7'd0, mPson});
      chk("R5/R8 railData", {4'd0, railData}, {4'd0, {4{!sleep}}});
      chk("R8 railOe", {4'd0, railOe}, {4'd0, oeExp});
      chk("R9 s0Gate", {6'd0, s0GateData, s0GateOe},
          {6'd0, !mS5, !(mS5 && s0GateFloat)});
      chk("R9 s3Gate", {6'd0, s3GateData, s3GateOe},
          {6'd0, !mS5, !(mS5 && s3GateFloat)});
      chk("R10 wdtRstN", {7'd0, wdtRstN}, {7'd0, !(wdtFromPwrokEn && !mPwr)});
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic bounceAtx(input int len, input int times);
    for (int t = 0; t < times; t++) begin
      atxPgIn = ~atxPgIn; step(len);
    end
  endtask

  initial begin
    step(2);
    @(negedge clk);
    // R11: reset values at the ports
    chk("R11 reset pwrOk", {7'd0, pwrOk}, 8'd0);
    chk("R11 reset psonN", {7'd0, psonN}, 8'd1);
    chk("R11 reset pciRstN", {3'd0, pciRstN}, 8'd0);
    chk("R11 reset atxPgOut", {7'd0, atxPgOut}, 8'd0);
    step(1);
    rstN = 1'b1;
    vddOk = 1'b1;
    step(30);

    // R1: each delay setting
    for (int sel = 0; sel < 4; sel++) begin
      vddOk = 1'b0; step(5);
      delaySel = 2'(sel);
      vddOk = 1'b1; step(25);
    end
    // R2: drop in the middle of a count
    delaySel = 2'd3;
    vddOk = 1'b0; step(3);
    vddOk = 1'b1; step(6);
    vddOk = 1'b0; step(2);
    vddOk = 1'b1; step(25);

    // R3: short bounces rejected, long level accepted
    bounceAtx(5, 6);
    atxPgIn = 1'b1; step(30);
    bounceAtx(15, 2);
    atxPgIn = 1'b0; step(30);
    lpcRstNIn = 1'b1; step(30);
    lpcRstNIn = 1'b0; step(8);
    lpcRstNIn = 1'b1; step(30);
    atxDbEn = 1'b0; lpcDbEn = 1'b0;
    bounceAtx(3, 4);
    lpcRstNIn = 1'b0; step(4);
    lpcRstNIn = 1'b1; step(6);
    atxDbEn = 1'b1; lpcDbEn = 1'b1; step(25);

    // R4: PCI gates
    pciGate = 5'b10101; step(5);
    pciGate = 5'b00000; step(5);
    pciGate = 5'b01010; step(5);
    pciGate = 5'h1f; step(5);

    // R5, R8: S3 from supply-good, then from pin or software
    railFloat = 4'b1010;
    vddOk = 1'b0; step(10);
    vddOk = 1'b1; step(25);
    s3SrcSel = 1'b1; railFloat = 4'b0101;
    s3ReqN = 1'b0; step(10);
    s3ReqN = 1'b1; step(5);
    swS3 = 1'b1; step(10);
    swS3 = 1'b0; step(5);

    // R6: passthrough with delay disabled
    s3SrcSel = 1'b0;
    s3ReqN = 1'b0; step(4);
    s3ReqN = 1'b1; step(4);
    s3ReqN = 1'b0; step(1);
    s3ReqN = 1'b1; step(6);

    // R7: off-time guard
    psonDelayEn = 1'b1;
    s3ReqN = 1'b0; step(20);
    s3ReqN = 1'b1; step(60);
    step(130);
    s3ReqN = 1'b0; step(3);
    s3ReqN = 1'b1; step(200);

    // R9: soft-off gates, float and driven
    slpS5N = 1'b0; step(10);
    s0GateFloat = 1'b0; step(5);
    s3GateFloat = 1'b0; railFloat = 4'b0000; step(5);
    slpS5N = 1'b1; step(5);
    s0GateFloat = 1'b1; s3GateFloat = 1'b1;

    // R10: watchdog reset from power good
    wdtFromPwrokEn = 1'b1; step(3);
    vddOk = 1'b0; step(5);
    vddOk = 1'b1; step(25);
    wdtFromPwrokEn = 1'b0; step(5);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule